// File: doc/BRIEF.md
# Training Sequence Insertion Scheduler

This block sits beside the packet arbiter of a SPI-4.2 style transmit datapath and decides when data must pause so that a periodic training sequence can be sent. An interval counter runs through the idle (non-training) cycles. When the programmed interval has elapsed, the block requests a stall, and training then runs for a programmed number of repetitions of a fixed-length pattern. After that the interval starts again from zero.

The first burst of a packet, the one carrying start-of-packet, can optionally be protected. In that mode a due training request waits until the burst has carried a programmed minimum number of 8-byte blocks, or until the burst ends. A forced-training input, driven by loss of sync or a disabled interface, overrides the schedule and holds training on for as long as it is asserted. The training words and the data path itself lie outside this block.

Top module: `train_sched`

## Requirements
- R1: While reset is asserted, `stall` and `train_active` are 0, even if `force_train` is high.
- R2: No scheduled training occurs while `cfg_max_t` is 0 or `cfg_alpha` is 0.
- R3: `cfg_err` is 1 in two cases. The first is a nonzero `cfg_max_t` that is not a multiple of 4 or is below 32. The second is an odd `cfg_minb` while the hold-off mode is in effect (both `cfg_hold_en` and `cfg_spi4` are 1). While `cfg_err` is 1, no scheduled training occurs.
- R4: After reset is released, `train_active` rises on the `cfg_max_t`-th rising clock edge, so that exactly `cfg_max_t` idle cycles come first.
- R5: A scheduled training period lasts `cfg_alpha` × PAT_LEN cycles (PAT_LEN defaults to 4). After it ends, the next one starts after another `cfg_max_t` idle cycles.
- R6: `stall` leads `train_active` by one cycle: `train_active` in each cycle equals `stall` in the cycle before.
- R7: When hold-off is in effect and training falls due during the first burst of a packet, `stall` is withheld until that burst has carried `cfg_minb` blocks. A burst starts with a cycle where `pkt_valid` and `pkt_sop` are both 1, and each cycle with `pkt_valid` carries one block. `stall` is then raised in the cycle carrying the `cfg_minb`-th block, or in the cycle carrying `pkt_burst_end`, whichever comes first.
- R8: Bursts that do not begin with `pkt_sop` get no hold-off. Training cuts them as soon as it falls due.
- R9: When `cfg_spi4` is 0 or `cfg_hold_en` is 0, start-of-packet bursts get no hold-off.
- R10: `stall` is 1 in every cycle in which `force_train` is 1, and `train_active` follows one cycle later. In the cycle `force_train` drops, `stall` drops and `train_active` falls at the next edge. The interval then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_t | input | 16 | Idle cycles between training periods (0 disables) |
| cfg_alpha | input | 16 | Pattern repetitions per training period (0 disables) |
| cfg_minb | input | 9 | Minimum first-burst size in 8-byte blocks |
| cfg_hold_en | input | 1 | Enables the first-burst hold-off |
| cfg_spi4 | input | 1 | Link is in SPI-4 mode; hold-off applies only when set |
| force_train | input | 1 | Forces continuous training while high |
| pkt_valid | input | 1 | A data block is sent this cycle |
| pkt_sop | input | 1 | The block this cycle starts a packet |
| pkt_burst_end | input | 1 | The block this cycle ends the current burst |
| stall | output | 1 | Datapath must send no data from the next cycle |
| train_active | output | 1 | Training pattern is being sent this cycle |
| cfg_err | output | 1 | Configuration values are illegal |

## Verification
Two events can fall in the same cycle: the interval expiring and the hold-off on a start-of-packet burst. To provoke this, the bench starts a first burst a few cycles before the interval is due. It then judges the exact edge on which `train_active` rises. With hold-off, that edge is the start cycle plus `cfg_minb`. With the burst ended early, with a burst that has no start-of-packet, or with the mode off, it is the plain `cfg_max_t`. The overlap of a forced-training window with the schedule is judged by checking that the interval restarts from zero after release.

// File: rtl/train_sched.sv
module train_sched #(
  parameter int VAL_W    = 16,
  parameter int MINB_W   = 9,
  parameter int PAT_LEN  = 4,
  parameter int MIN_MAXT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAL_W-1:0]  cfg_max_t,
  input  logic [VAL_W-1:0]  cfg_alpha,
  input  logic [MINB_W-1:0] cfg_minb,
  input  logic              cfg_hold_en,
  input  logic              cfg_spi4,
  input  logic              force_train,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic              pkt_burst_end,
  output logic              stall,
  output logic              train_active,
  output logic              cfg_err
);
  localparam int PAT_W = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

  logic              act, frc, in_first;
  logic [VAL_W-1:0]  ivl, rep;
  logic [PAT_W-1:0]  pat;
  logic [MINB_W-1:0] blk;

  wire hold_mode = cfg_hold_en & cfg_spi4;

  assign cfg_err = ((cfg_max_t != '0) &&
                    ((cfg_max_t[1:0] != 2'b00) || (cfg_max_t < VAL_W'(MIN_MAXT)))) ||
                   (hold_mode && cfg_minb[0]);

  wire sched_en = (cfg_max_t != '0) && (cfg_alpha != '0) && !cfg_err;
  wire due      = ivl >= (cfg_max_t - VAL_W'(1));

  wire              sop_now   = pkt_valid & pkt_sop;
  wire              burst_fin = pkt_valid & pkt_burst_end;
  wire              first_now = in_first | sop_now;
  wire [MINB_W-1:0] cnt_nxt   = (sop_now ? '0 : blk) + MINB_W'(pkt_valid);
  wire              short_yet = cnt_nxt < cfg_minb;
  wire              hold_now  = hold_mode & first_now & short_yet & !burst_fin;

  wire last_pat = pat == PAT_W'(PAT_LEN - 1);
  wire last_rep = rep == (cfg_alpha - VAL_W'(1));
  wire ending   = !sched_en | (last_pat & last_rep);
  wire start    = sched_en & !act & due & !hold_now;

  assign stall        = rst_n & (force_train | start | (act & !frc & !ending));
  assign train_active = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      frc      <= 1'b0;
      in_first <= 1'b0;
      ivl      <= '0;
      rep      <= '0;
      pat      <= '0;
      blk      <= '0;
    end else begin
      in_first <= first_now & !burst_fin & short_yet;
      blk      <= first_now ? cnt_nxt : '0;
      if (force_train) begin
        act <= 1'b1;
        frc <= 1'b1;
        pat <= '0;
        rep <= '0;
        ivl <= '0;
      end else if (act) begin
        if (frc || ending) begin
          act <= 1'b0;
          frc <= 1'b0;
          pat <= '0;
          rep <= '0;
          ivl <= '0;
        end else if (last_pat) begin
          pat <= '0;
          rep <= rep + VAL_W'(1);
        end else begin
          pat <= pat + PAT_W'(1);
        end
      end else if (start) begin
        act <= 1'b1;
        frc <= 1'b0;
        pat <= '0;
        rep <= '0;
      end else if (sched_en && ivl != '1) begin
        ivl <= ivl + VAL_W'(1);
      end
    end
  end
endmodule

// File: rtl/train_sched_chk.sv
module train_sched_chk #(
  parameter int VAL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VAL_W-1:0] cfg_max_t,
  input logic [VAL_W-1:0] cfg_alpha,
  input logic             force_train,
  input logic             stall,
  input logic             train_active,
  input logic             cfg_err
);
  a_r6_stall_leads: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> train_active);

  a_r6_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> !train_active);

  a_r2_off_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_max_t == '0) || (cfg_alpha == '0)) && !force_train |-> !stall);

  a_r3_err_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err && !force_train |-> !stall);

  a_r10_force_stall: assert property (@(posedge clk) disable iff (!rst_n)
    force_train |-> stall);

  a_r10_force_active: assert property (@(posedge clk) disable iff (!rst_n)
    force_train |=> train_active);
endmodule

bind train_sched train_sched_chk #(.VAL_W(VAL_W)) u_chk (.*);

// File: tb/sim_train_sched.sv
`timescale 1ns/1ps
module sim_train_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_max_t = '0;
  logic [15:0] cfg_alpha = '0;
  logic [8:0]  cfg_minb = '0;
  logic        cfg_hold_en = 1'b0;
  logic        cfg_spi4 = 1'b0;
  logic        force_train = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_sop = 1'b0;
  logic        pkt_burst_end = 1'b0;
  logic        stall, train_active, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  train_sched u0 (.*);

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic setup(int mt, int al, int mb, bit hold, bit spi4);
    rst_n = 1'b0;
    force_train = 1'b0;
    pkt_valid = 1'b0;
    pkt_sop = 1'b0;
    pkt_burst_end = 1'b0;
    cfg_max_t = 16'(mt);
    cfg_alpha = 16'(al);
    cfg_minb = 9'(mb);
    cfg_hold_en = hold;
    cfg_spi4 = spi4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic until_active(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!train_active && n < 3000);
  endtask

  task automatic t_reset;
    setup(32, 2, 0, 0, 0);
    rst_n = 1'b0;
    force_train = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 stall in reset", stall, 0);
    chk("R1 active in reset", train_active, 0);
    force_train = 1'b0;
  endtask

  task automatic t_interval(int mt, int al);
    int n;
    int len;
    bit prev;
    setup(mt, al, 0, 0, 0);
    n = 0;
    prev = 1'b0;
    do begin
      prev = stall;
      @(negedge clk);
      n++;
    end while (!train_active && n < 3000);
    chk("R4 first training edge", n, mt);
    chk("R6 stall one cycle ahead", prev, 1);
    len = 0;
    do begin
      prev = stall;
      @(negedge clk);
      len++;
    end while (train_active && len < 3000);
    chk("R5 training length", len, al * 4);
    chk("R6 stall low before end", prev, 0);
    until_active(n);
    chk("R5 interval restart", n, mt);
  endtask

  task automatic t_disabled;
    int seen;
    setup(0, 2, 0, 0, 0);
    seen = 0;
    repeat (200) begin @(negedge clk); seen += train_active; end
    chk("R2 max_t zero", seen, 0);
    setup(32, 0, 0, 0, 0);
    seen = 0;
    repeat (200) begin @(negedge clk); seen += train_active; end
    chk("R2 alpha zero", seen, 0);
  endtask

  task automatic t_cfg_err;
    int seen;
    setup(34, 1, 0, 0, 0);
    #1 chk("R3 max_t not multiple of 4", cfg_err, 1);
    seen = 0;
    repeat (150) begin @(negedge clk); seen += train_active; end
    chk("R3 error suppresses training", seen, 0);
    setup(16, 1, 0, 0, 0);
    #1 chk("R3 max_t below 32", cfg_err, 1);
    setup(36, 1, 0, 0, 0);
    #1 chk("R3 legal max_t", cfg_err, 0);
    setup(36, 1, 7, 1, 1);
    #1 chk("R3 odd minb with hold-off", cfg_err, 1);
    setup(36, 1, 7, 1, 0);
    #1 chk("R3 odd minb without spi4", cfg_err, 0);
  endtask

  task automatic run_burst(int start_n, bit sop, int end_n, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      pkt_sop = 1'b0;
      pkt_burst_end = 1'b0;
      if (n == start_n) begin pkt_valid = 1'b1; pkt_sop = sop; end
      if (n == end_n) pkt_burst_end = 1'b1;
      if (n > end_n) pkt_valid = 1'b0;
    end while (!train_active && n < 3000);
    pkt_valid = 1'b0;
    pkt_sop = 1'b0;
    pkt_burst_end = 1'b0;
  endtask

  task automatic t_hold;
    int n;
    setup(32, 1, 10, 1, 1);
    run_burst(25, 1, 1000, n);
    chk("R7 first burst protected", n, 35);
    setup(32, 1, 10, 1, 1);
    run_burst(25, 1, 28, n);
    chk("R7 burst ended early", n, 32);
    setup(32, 1, 10, 1, 1);
    run_burst(25, 0, 1000, n);
    chk("R8 later burst cut", n, 32);
    setup(32, 1, 10, 1, 0);
    run_burst(25, 1, 1000, n);
    chk("R9 non-spi4 no hold", n, 32);
    setup(32, 1, 10, 0, 1);
    run_burst(25, 1, 1000, n);
    chk("R9 hold disabled", n, 32);
  endtask

  task automatic t_force;
    int n;
    setup(32, 2, 0, 0, 0);
    repeat (10) @(negedge clk);
    force_train = 1'b1;
    #1 chk("R10 stall on force", stall, 1);
    @(negedge clk);
    chk("R10 active after force", train_active, 1);
    repeat (50) @(negedge clk);
    chk("R10 held through interval", train_active, 1);
    force_train = 1'b0;
    #1 chk("R10 stall drops on release", stall, 0);
    @(negedge clk);
    chk("R10 active drops", train_active, 0);
    until_active(n);
    chk("R10 interval restarts", n, 32);
  endtask

  initial begin
    t_reset();
    t_interval(32, 2);
    t_interval(40, 3);
    t_disabled();
    t_cfg_err();
    t_hold();
    t_force();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule